// File: doc/BRIEF.md
# Counter-Based Oscillator Frequency Calibrator

This block sits in the reference clock domain of a frequency synthesizer. It pulls the free-running frequency of an oscillator toward a multiple of a reference PLL. Two divided-down clocks arrive asynchronously, one derived from the oscillator and one from the PLL. The block synchronizes both and counts their rising edges over a fixed window of reference cycles. At the end of each window it forms the signed difference between the PLL count and the oscillator count. It then moves a fine-tuning DAC code by a single LSB toward agreement. Only the sign of the difference is used, never its size.

After reset a coarse capacitor-bank setting is latched from a preset input. The DAC code starts at mid-scale. Fine calibration runs only while the reference PLL reports lock and the calibration-permit slot signal is high. If either one drops, the window in progress is thrown away. In the initial phase, measured windows run back to back until the loop is judged converged. After that the block either freezes its codes or, in intermittent mode, checks for drift. In intermittent mode one measured window is followed by a programmable number of idle windows. Only one set of codes is held at a time.

Top module: `osc_freq_cal`

## Requirements
- R1: Once reset is released, `bank_code` takes the value of `coarse_preset` and `dac_code` starts at mid-scale (32 for a 6-bit code). The bank code does not change again until the next reset.
- R2: Windows advance only while both `pll_locked` and `cal_permit` are 1. If either is 0, the window in progress is discarded, no `win_done` pulse occurs and `dac_code` holds.
- R3: A window lasts `WIN_CYCLES` (10) reference cycles. In the initial phase, with the gate held open, `win_done` pulses every 10 cycles.
- R4: With each `win_done` pulse, `err_out` shows the rising edges of `pll_div_clk` minus the rising edges of `osc_div_clk` seen in that window, as a two's-complement number.
- R5: At a `win_done` pulse, `dac_code` has dropped by 1 if `err_out` is negative, has risen by 1 if it is positive, and is unchanged if it is zero.
- R6: `dac_code` saturates at 0 and at its all-ones value and never wraps around.
- R7: In the initial phase, `cal_done` rises at the first window whose error is zero, or whose error sign is opposite to that of the previous nonzero error. While the error keeps one sign, `cal_done` stays 0.
- R8: Once `cal_done` is 1 and `mode_sel` is 0, no further windows are measured and `dac_code` stays frozen whatever the divided clocks do.
- R9: Once `cal_done` is 1 and `mode_sel` is 1, each measured window is followed by `monitor_gap` idle windows. Measured windows therefore complete every (`monitor_gap`+1)·10 cycles, and each one still applies the R5 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock of the calibration logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pll_div_clk | input | 1 | Divided clock from the reference PLL (asynchronous) |
| osc_div_clk | input | 1 | Divided down-converted clock from the oscillator (asynchronous) |
| pll_locked | input | 1 | Reference PLL lock indication |
| cal_permit | input | 1 | Calibration time slot is open |
| mode_sel | input | 1 | 0: hold after convergence; 1: intermittent drift monitoring |
| monitor_gap | input | GAP_W | Idle windows between measured windows in intermittent operation |
| coarse_preset | input | BANK_W | Coarse capacitor-bank setting latched after reset |
| dac_code | output | DAC_W | Fine-tuning DAC code |
| bank_code | output | BANK_W | Applied capacitor-bank code |
| err_out | output | CNT_W+1 | Signed count difference of the last measured window |
| win_done | output | 1 | One-cycle pulse when a measured window has completed |
| cal_done | output | 1 | Initial convergence reached |

## Verification
The divided clocks are driven with periods of 2, 5 and 10 reference cycles, or held low. Each of these fits a whole number of times into a window, so every full window has an exact, known edge count. Equal periods give a zero error and separate the convergence-on-zero rule from the step logic. Constant-sign pairs drive the code into both rails without setting `cal_done`, which separates saturation from wrap and from false convergence. A mid-run swap of the faster clock separates the sign-flip rule. Random period pairs, gap values and gate dropouts check the error value and the one-LSB step on every completed window, and check that no window completes while the gate is closed.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_INIT = 2'd1,
    PH_MON  = 2'd2,
    PH_HOLD = 2'd3
  } cal_phase_t;
endpackage

// File: rtl/edge_sync_counter.sv
module edge_sync_counter #(
  parameter int WIN   = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             async_in,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_next
);
  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], async_in};
  end

  assign rise     = sync_q[1] & ~sync_q[2];
  assign cnt_next = cnt_q + CNT_W'(en & rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_next;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= WIN); // R4
endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int WIN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic win_end
);
  localparam int WCNT_W = (WIN > 1) ? $clog2(WIN) : 1;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;

  assign win_end = active && (wcnt_q == WCNT_W'(WIN - 1));

  always_comb begin
    if (!active)     wcnt_d = '0;
    else if (win_end) wcnt_d = '0;
    else             wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wcnt_q) < WIN); // R3
endmodule

// File: rtl/osc_freq_cal.sv
module osc_freq_cal
  import osc_cal_pkg::*;
#(
  parameter int DAC_W      = 6,
  parameter int BANK_W     = 4,
  parameter int GAP_W      = 4,
  parameter int WIN_CYCLES = 10,
  parameter int CNT_W      = $clog2(WIN_CYCLES + 1)
) (
  input  logic                    clk_ref,
  input  logic                    rst_n,
  input  logic                    pll_div_clk,
  input  logic                    osc_div_clk,
  input  logic                    pll_locked,
  input  logic                    cal_permit,
  input  logic                    mode_sel,
  input  logic [GAP_W-1:0]        monitor_gap,
  input  logic [BANK_W-1:0]       coarse_preset,
  output logic [DAC_W-1:0]        dac_code,
  output logic [BANK_W-1:0]       bank_code,
  output logic signed [CNT_W:0]   err_out,
  output logic                    win_done,
  output logic                    cal_done
);
  localparam int ERR_W = CNT_W + 1;
  localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W - 1);
  localparam logic [DAC_W-1:0] DAC_MAX = '1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  cal_phase_t              phase_q, phase_d;
  logic [DAC_W-1:0]        dac_q, dac_d;
  logic [BANK_W-1:0]       bank_q, bank_d;
  logic signed [ERR_W-1:0] err_q, err_d;
  logic                    done_q, done_d;
  logic                    wdone_q, wdone_d;
  logic [GAP_W-1:0]        gap_q, gap_d;
  logic                    prev_neg_q, prev_neg_d;
  logic                    prev_vld_q, prev_vld_d;

  logic                    running, active, measure, win_end, cnt_clr;
  logic [CNT_W-1:0]        pll_cnt, osc_cnt;
  logic signed [ERR_W-1:0] err_now;
  logic                    converged;

  assign running = (phase_q == PH_INIT) || (phase_q == PH_MON);
  assign active  = pll_locked && cal_permit && running;
  assign measure = (phase_q == PH_INIT) || ((phase_q == PH_MON) && (gap_q == '0));
  assign cnt_clr = win_end || !active;

  window_timer #(.WIN(WIN_CYCLES)) u_timer (
    .clk(clk_ref), .rst_n(rst_int), .active(active), .win_end(win_end)
  );

  edge_sync_counter #(.WIN(WIN_CYCLES), .CNT_W(CNT_W)) u_pll_cnt (
    .clk(clk_ref), .rst_n(rst_int), .async_in(pll_div_clk),
    .clr(cnt_clr), .en(measure), .cnt_next(pll_cnt)
  );

  edge_sync_counter #(.WIN(WIN_CYCLES), .CNT_W(CNT_W)) u_osc_cnt (
    .clk(clk_ref), .rst_n(rst_int), .async_in(osc_div_clk),
    .clr(cnt_clr), .en(measure), .cnt_next(osc_cnt)
  );

  assign err_now   = $signed({1'b0, pll_cnt}) - $signed({1'b0, osc_cnt});
  assign converged = (err_now == '0) || (prev_vld_q && ((err_now < 0) != prev_neg_q));

  function automatic logic [DAC_W-1:0] step_code(input logic [DAC_W-1:0] c,
                                                 input logic signed [ERR_W-1:0] e);
    if (e < 0 && c != '0)          return c - 1'b1;
    else if (e > 0 && c != DAC_MAX) return c + 1'b1;
    else                            return c;
  endfunction

  always_comb begin
    phase_d    = phase_q;
    dac_d      = dac_q;
    bank_d     = bank_q;
    err_d      = err_q;
    done_d     = done_q;
    wdone_d    = 1'b0;
    gap_d      = gap_q;
    prev_neg_d = prev_neg_q;
    prev_vld_d = prev_vld_q;
    unique case (phase_q)
      PH_LOAD: begin
        bank_d     = coarse_preset;
        dac_d      = DAC_MID;
        done_d     = 1'b0;
        prev_vld_d = 1'b0;
        gap_d      = '0;
        phase_d    = PH_INIT;
      end
      PH_INIT: begin
        if (win_end) begin
          dac_d   = step_code(dac_q, err_now);
          err_d   = err_now;
          wdone_d = 1'b1;
          if (err_now != '0) begin
            prev_neg_d = (err_now < 0);
            prev_vld_d = 1'b1;
          end
          if (converged) begin
            done_d  = 1'b1;
            gap_d   = monitor_gap;
            phase_d = mode_sel ? PH_MON : PH_HOLD;
          end
        end
      end
      PH_MON: begin
        if (!mode_sel) begin
          phase_d = PH_HOLD;
        end else if (win_end) begin
          if (gap_q != '0) begin
            gap_d = gap_q - 1'b1;
          end else begin
            dac_d   = step_code(dac_q, err_now);
            err_d   = err_now;
            wdone_d = 1'b1;
            gap_d   = monitor_gap;
          end
        end
      end
      PH_HOLD: begin
        if (mode_sel) begin
          gap_d   = '0;
          phase_d = PH_MON;
        end
      end
      default: phase_d = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_int) begin
    if (!rst_int) begin
      phase_q    <= PH_LOAD;
      dac_q      <= '0;
      bank_q     <= '0;
      err_q      <= '0;
      done_q     <= 1'b0;
      wdone_q    <= 1'b0;
      gap_q      <= '0;
      prev_neg_q <= 1'b0;
      prev_vld_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      dac_q      <= dac_d;
      bank_q     <= bank_d;
      err_q      <= err_d;
      done_q     <= done_d;
      wdone_q    <= wdone_d;
      gap_q      <= gap_d;
      prev_neg_q <= prev_neg_d;
      prev_vld_q <= prev_vld_d;
    end
  end

  assign dac_code  = dac_q;
  assign bank_code = bank_q;
  assign err_out   = err_q;
  assign win_done  = wdone_q;
  assign cal_done  = done_q;

  AST_BANK_FIXED: assert property (@(posedge clk_ref) disable iff (!rst_int)
    (phase_q != PH_LOAD && $past(phase_q) != PH_LOAD) |-> $stable(bank_q)); // R1
  AST_GATE_CLOSED: assert property (@(posedge clk_ref) disable iff (!rst_int)
    !(pll_locked && cal_permit) |=> !win_done); // R2
  AST_DEC_STEP: assert property (@(posedge clk_ref) disable iff (!rst_int)
    (win_done && err_out < 0 && $past(dac_q) != '0) |-> (dac_q == $past(dac_q) - 1'b1)); // R5
  AST_INC_STEP: assert property (@(posedge clk_ref) disable iff (!rst_int)
    (win_done && err_out > 0 && $past(dac_q) != DAC_MAX) |-> (dac_q == $past(dac_q) + 1'b1)); // R5
  AST_ZERO_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_int)
    (win_done && err_out == 0) |-> $stable(dac_q)); // R5
  AST_NO_WRAP: assert property (@(posedge clk_ref) disable iff (!rst_int)
    ($past(phase_q) != PH_LOAD && $past(dac_q) == DAC_MAX) |-> (dac_q != '0)); // R6
  AST_HOLD_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_int)
    (phase_q == PH_HOLD) |=> $stable(dac_q)); // R8
endmodule

// File: tb/sim_osc_freq_cal.sv
`timescale 1ns/1ps
module sim_osc_freq_cal;
  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       pll_div_clk, osc_div_clk;
  logic       pll_locked, cal_permit, mode_sel;
  logic [3:0] monitor_gap;
  logic [3:0] coarse_preset;
  logic [5:0] dac_code;
  logic [3:0] bank_code;
  logic signed [4:0] err_out;
  logic       win_done, cal_done;

  osc_freq_cal u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .pll_div_clk(pll_div_clk), .osc_div_clk(osc_div_clk),
    .pll_locked(pll_locked), .cal_permit(cal_permit), .mode_sel(mode_sel),
    .monitor_gap(monitor_gap), .coarse_preset(coarse_preset), .dac_code(dac_code),
    .bank_code(bank_code), .err_out(err_out), .win_done(win_done), .cal_done(cal_done)
  );

  always #10 clk_ref = ~clk_ref;

  int checks = 0, failures = 0;
  int pp_per = 0, po_per = 0, ph_p = 0, ph_o = 0;
  int skip = 0, last_dac = 0, cycle = 0, last_wd = 0, wd_gap = 0, wd_count = 0;
  bit gate_at_edge = 0;
  bit finished = 0;

  function automatic int edges(int p);
    return (p == 0) ? 0 : 10 / p;
  endfunction

  function automatic int model_step(int c, int e);
    if (e < 0 && c > 0) return c - 1;
    if (e > 0 && c < 63) return c + 1;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycle);
    end
  endtask

  always @(posedge clk_ref) gate_at_edge <= pll_locked && cal_permit;

  always @(negedge clk_ref) begin
    cycle++;
    if (rst_n && win_done) begin
      wd_gap  = cycle - last_wd;
      last_wd = cycle;
      wd_count++;
      chk("R2 window completed with gate closed", int'(gate_at_edge), 1);
      if (skip > 0) skip--;
      else begin
        chk("R4 error value", int'(err_out), edges(pp_per) - edges(po_per));
        chk("R5/R6 dac step", int'(dac_code), model_step(last_dac, edges(pp_per) - edges(po_per)));
      end
    end
    last_dac = int'(dac_code);
    ph_p = (pp_per == 0 || ph_p + 1 >= pp_per) ? 0 : ph_p + 1;
    ph_o = (po_per == 0 || ph_o + 1 >= po_per) ? 0 : ph_o + 1;
    pll_div_clk <= (pp_per != 0) && (ph_p < pp_per / 2);
    osc_div_clk <= (po_per != 0) && (ph_o < po_per / 2);
  end

  task automatic set_clocks(int p, int o);
    pp_per = p; po_per = o; skip = 3;
  endtask

  task automatic do_reset(logic [3:0] preset, logic mode);
    @(negedge clk_ref);
    rst_n = 1'b0;
    coarse_preset = preset;
    mode_sel = mode;
    repeat (3) @(negedge clk_ref);
    skip = 3;
    rst_n = 1'b1;
  endtask

  function automatic int pick_per(int k);
    case (k)
      0: return 0;
      1: return 2;
      2: return 5;
      default: return 10;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; pll_locked = 1'b1; cal_permit = 1'b1; mode_sel = 1'b0;
    monitor_gap = 4'd0; coarse_preset = 4'd0;
    pll_div_clk = 1'b0; osc_div_clk = 1'b0;

    // R1: reset state and preset load
    set_clocks(5, 2);
    do_reset(4'hA, 1'b0);
    repeat (6) @(negedge clk_ref);
    chk("R1 dac mid-scale", int'(dac_code), 32);
    chk("R1 bank preset", int'(bank_code), 10);
    chk("R7 done low after reset", int'(cal_done), 0);

    // R6 low rail, R3 spacing, R7 no convergence with constant sign
    repeat (450) @(negedge clk_ref);
    chk("R6 saturate at zero", int'(dac_code), 0);
    chk("R3 window spacing", wd_gap, 10);
    chk("R7 constant sign keeps done low", int'(cal_done), 0);
    chk("R1 bank unchanged", int'(bank_code), 10);

    // R6 high rail
    set_clocks(2, 0);
    do_reset(4'h3, 1'b0);
    repeat (700) @(negedge clk_ref);
    chk("R6 saturate at max", int'(dac_code), 63);
    chk("R1 bank preset 2", int'(bank_code), 3);

    // R2 gating
    set_clocks(5, 2);
    do_reset(4'h1, 1'b0);
    repeat (40) @(negedge clk_ref);
    begin
      int d0, n0;
      pll_locked = 1'b0;
      @(negedge clk_ref);
      d0 = int'(dac_code); n0 = wd_count;
      repeat (100) @(negedge clk_ref);
      chk("R2 no windows without lock", wd_count, n0);
      chk("R2 dac frozen without lock", int'(dac_code), d0);
      pll_locked = 1'b1; cal_permit = 1'b0;
      @(negedge clk_ref);
      n0 = wd_count;
      repeat (100) @(negedge clk_ref);
      chk("R2 no windows without permit", wd_count, n0);
      chk("R2 dac frozen without permit", int'(dac_code), d0);
      cal_permit = 1'b1;
      repeat (30) @(negedge clk_ref);
      chk("R2 windows resume", int'(wd_count > n0), 1);
    end

    // R7 sign alternation
    set_clocks(5, 2);
    do_reset(4'h2, 1'b0);
    repeat (60) @(negedge clk_ref);
    chk("R7 done low before flip", int'(cal_done), 0);
    set_clocks(5, 10);
    repeat (45) @(negedge clk_ref);
    chk("R7 done after sign flip", int'(cal_done), 1);

    // R7 zero error, R8 hold
    set_clocks(5, 5);
    do_reset(4'h4, 1'b0);
    repeat (60) @(negedge clk_ref);
    chk("R7 done on zero error", int'(cal_done), 1);
    begin
      int d0, n0;
      set_clocks(5, 2);
      @(negedge clk_ref);
      d0 = int'(dac_code); n0 = wd_count;
      repeat (120) @(negedge clk_ref);
      chk("R8 no windows in hold", wd_count, n0);
      chk("R8 dac frozen in hold", int'(dac_code), d0);
    end

    // R9 intermittent spacing and drift tracking
    monitor_gap = 4'd3;
    set_clocks(5, 5);
    do_reset(4'h5, 1'b1);
    repeat (60) @(negedge clk_ref);
    chk("R9 converged before monitoring", int'(cal_done), 1);
    begin
      int d0;
      d0 = int'(dac_code);
      set_clocks(5, 2);
      repeat (200) @(negedge clk_ref);
      chk("R9 measured window spacing", wd_gap, 40);
      chk("R9 drift corrected downward", int'(int'(dac_code) < d0), 1);
    end

    // Random: R4/R5 on every window, R2 on gate drops
    monitor_gap = 4'd0;
    set_clocks(5, 5);
    do_reset(4'h6, 1'b1);
    for (int it = 0; it < 30; it++) begin
      set_clocks(pick_per($urandom_range(0, 3)), pick_per($urandom_range(0, 3)));
      monitor_gap = 4'($urandom_range(0, 3));
      repeat ($urandom_range(100, 300)) @(negedge clk_ref);
      if ($urandom_range(0, 2) == 0) begin
        if ($urandom_range(0, 1) == 0) pll_locked = 1'b0; else cal_permit = 1'b0;
        repeat ($urandom_range(5, 30)) @(negedge clk_ref);
        pll_locked = 1'b1; cal_permit = 1'b1;
      end
    end
    repeat (50) @(negedge clk_ref);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule